// File: doc/BRIEF.md
# Flash Sector Protection Register

This block holds the write-protection state for the sectors of an embedded nonvolatile memory. The low address space has sixteen lock bits, one for each sector. A separate bit covers the test/shadow region. Program and erase logic reads a protection vector that combines these bits with a secondary lock register held elsewhere. A sector can be changed only when both its primary lock bit and its secondary lock bit are clear. The test region can never be erased.

Each time reset is asserted, the lock state is reloaded from a nonvolatile configuration word. An erased word reads as all ones, so every sector starts out locked. Software can rewrite the locks through a simple register port, but only under these conditions:

- the lock-modify enable input is high;
- no interlocked program or erase operation is pending;
- no high-voltage operation is suspended.

The number of sectors that actually exist is fixed at elaboration. The lock bits above that count are permanently set.

Top module: `flash_lock_reg`

## Requirements
- R1: A lock bit value of 1 sets the matching bit of `low_prot`, which blocks program and erase of that sector. A sector is open only when its bit is 0 in both the primary and the secondary register.
- R2: While `lock_en` is low, register writes change nothing.
- R3: A cycle with `array_wr` high while `pe_armed` is high starts an interlock. From the next cycle on, register writes are refused until `op_done` is high. A write in the same cycle as `op_done` is still refused. A write in the cycle after that is accepted. `array_wr` with `pe_armed` low starts no interlock.
- R4: While `hv_suspended` is high, register writes change nothing.
- R5: While `rst_n` is low, each clock edge loads the locks from `cfg_word`. Sector bits come from bits 15:0 and the test bit from bit 20. An all-ones `cfg_word` leaves every sector and the test region locked.
- R6: Sector lock bits at index `IMPL_SECTORS` and above always read 1 and ignore both writes and `cfg_word`.
- R7: The read image `rd_data` holds the sector locks in bits 15:0 and the test lock in bit 20. Every other bit reads 0, whatever is written to it.
- R8: `low_prot` is the bitwise OR of the sector lock bits and `sec_lock`. `test_pgm_prot` is the OR of the test lock bit and `sec_test_lock`.
- R9: `test_erase_prot` is always 1.
- R10: An accepted write takes effect on the clock edge that samples it and is visible on `rd_data` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads locks from cfg_word |
| cfg_word | input | 32 | Nonvolatile configuration value loaded during reset |
| lock_en | input | 1 | Lock-modify enable; writes are honoured only while high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read image |
| array_wr | input | 1 | Write to the memory array address space |
| pe_armed | input | 1 | A program or erase operation is armed |
| op_done | input | 1 | Requested operation has completed |
| hv_suspended | input | 1 | A high-voltage operation is suspended |
| sec_lock | input | 16 | Secondary sector lock bits |
| sec_test_lock | input | 1 | Secondary test-region lock bit |
| low_prot | output | 16 | Effective per-sector program/erase protection |
| test_pgm_prot | output | 1 | Effective test-region program protection |
| test_erase_prot | output | 1 | Test-region erase protection, always set |

## Verification
A wrong lock bit appears on `rd_data` and `low_prot` in the cycle after the edge that stored it. A sweep over every pattern of the implemented bits catches a stuck or swapped bit on the first read. A wrong interlock flag stays hidden until a register write is attempted. It then shows up on the next read, either as a refused write that should have been taken or as an accepted write that should have been refused. For that reason the bench probes writes just before `op_done`, at `op_done` and just after it. A bad reset load shows on the first read after reset is released.

// File: rtl/flash_lock_reg.sv
module flash_lock_reg #(
  parameter int LOW_W        = 16,
  parameter int IMPL_SECTORS = 6,
  parameter int TEST_BIT     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_word,
  input  logic             lock_en,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  output logic [31:0]      rd_data,
  input  logic             array_wr,
  input  logic             pe_armed,
  input  logic             op_done,
  input  logic             hv_suspended,
  input  logic [LOW_W-1:0] sec_lock,
  input  logic             sec_test_lock,
  output logic [LOW_W-1:0] low_prot,
  output logic             test_pgm_prot,
  output logic             test_erase_prot
);
  localparam logic [LOW_W-1:0] IMPL_MASK = LOW_W'((64'd1 << IMPL_SECTORS) - 64'd1);
  localparam logic [LOW_W-1:0] ABSENT    = ~IMPL_MASK;

  logic [LOW_W-1:0] lock_q;
  logic             test_q;
  logic             pend_q;
  logic             wr_ok;

  assign wr_ok = wr_en && lock_en && !pend_q && !hv_suspended;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q <= (cfg_word[LOW_W-1:0] & IMPL_MASK) | ABSENT;
      test_q <= cfg_word[TEST_BIT];
      pend_q <= 1'b0;
    end else begin
      if (wr_ok) begin
        lock_q <= (wr_data[LOW_W-1:0] & IMPL_MASK) | ABSENT;
        test_q <= wr_data[TEST_BIT];
      end
      if (op_done)                    pend_q <= 1'b0;
      else if (array_wr && pe_armed)  pend_q <= 1'b1;
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[LOW_W-1:0]    = lock_q;
    rd_data[TEST_BIT]     = test_q;
  end

  assign low_prot        = lock_q | sec_lock;
  assign test_pgm_prot   = test_q | sec_test_lock;
  assign test_erase_prot = 1'b1;

  p_nolock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_en |=> $stable(rd_data));
  p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(rd_data));
  p_arm_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (array_wr && pe_armed && !op_done) |=> pend_q);
  p_done_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !pend_q);
  p_susp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hv_suspended |=> $stable(rd_data));
  p_absent_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[LOW_W-1:0] & ABSENT) == ABSENT);
  p_effective_r8: assert property (@(posedge clk) disable iff (!rst_n)
    low_prot == (rd_data[LOW_W-1:0] | sec_lock));
endmodule

// File: tb/flash_lock_reg_bench.sv
module flash_lock_reg_bench;
  localparam int IMPL = 6;
  localparam logic [15:0] MASK = 16'((1 << IMPL) - 1);

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_word = '1, wr_data = '0, rd_data;
  logic lock_en = 0, wr_en = 0, array_wr = 0, pe_armed = 0, op_done = 0, hv_suspended = 0;
  logic [15:0] sec_lock = '0, low_prot;
  logic sec_test_lock = 0, test_pgm_prot, test_erase_prot;
  int runs = 0, fails = 0;

  always #2 clk = ~clk;

  flash_lock_reg #(.IMPL_SECTORS(IMPL)) u_flash_lock_reg (
    .clk, .rst_n, .cfg_word, .lock_en, .wr_en, .wr_data, .rd_data,
    .array_wr, .pe_armed, .op_done, .hv_suspended, .sec_lock, .sec_test_lock,
    .low_prot, .test_pgm_prot, .test_erase_prot);

  function automatic logic [31:0] img(logic [31:0] v);
    return {11'b0, v[20], 4'b0, (v[15:0] & MASK) | ~MASK};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [31:0] c);
    @(negedge clk); rst_n = 0; cfg_word = c;
    @(negedge clk); @(negedge clk); rst_n = 1; cfg_word = $urandom;
  endtask

  task automatic do_write(logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = $urandom;
  endtask

  initial begin
    #(4 * 200000);
    fails++; runs++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [31:0] cur;
    // R5 / R6 / R7: reset loads, including all-ones configuration
    do_reset('1);
    check("R5 erased cfg", rd_data, 32'h0010FFFF);
    check("R9 erase prot", {31'b0, test_erase_prot}, 32'd1);
    for (int i = 0; i < 128; i++) begin
      logic [31:0] c;
      c = $urandom;
      c[5:0] = i[5:0]; c[20] = i[6];
      do_reset(c);
      check("R5 R6 R7 reset load", rd_data, img(c));
    end
    // R10 / R6 / R7: write sweep, R1 / R8 effective outputs
    do_reset(32'h0);
    lock_en = 1;
    for (int i = 0; i < 128; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[5:0] = i[5:0]; d[20] = i[6];
      do_write(d);
      cur = img(d);
      check("R10 R6 R7 write image", rd_data, cur);
      for (int s = 0; s < 4; s++) begin
        sec_lock = 16'($urandom); sec_test_lock = s[0];
        #1;
        check("R1 R8 low_prot", {16'b0, low_prot}, {16'b0, cur[15:0] | sec_lock});
        check("R8 test_pgm_prot", {31'b0, test_pgm_prot}, {31'b0, cur[20] | sec_test_lock});
        check("R9 erase prot", {31'b0, test_erase_prot}, 32'd1);
      end
    end
    sec_lock = 0; sec_test_lock = 0;
    // R2: lock_en low
    cur = img(32'h0);
    do_write(32'h0);
    lock_en = 0;
    do_write(32'h0010003F);
    check("R2 write ignored lock_en low", rd_data, cur);
    lock_en = 1;
    // R4: suspended
    hv_suspended = 1;
    do_write(32'h0010003F);
    check("R4 write ignored suspended", rd_data, cur);
    hv_suspended = 0;
    // R3: array write without arming does not interlock
    @(negedge clk); array_wr = 1; pe_armed = 0;
    @(negedge clk); array_wr = 0;
    do_write(32'h00000015);
    cur = img(32'h15);
    check("R3 unarmed no interlock", rd_data, cur);
    // R3: armed interlock
    @(negedge clk); array_wr = 1; pe_armed = 1;
    @(negedge clk); array_wr = 0; pe_armed = 0;
    do_write(32'h0010002A);
    check("R3 refused while pending", rd_data, cur);
    do_write(32'h0010002A);
    check("R3 still refused", rd_data, cur);
    @(negedge clk); op_done = 1; wr_en = 1; wr_data = 32'h0010002A;
    @(negedge clk); op_done = 0; wr_en = 0;
    check("R3 refused at done", rd_data, cur);
    do_write(32'h0010002A);
    check("R3 accepted after done", rd_data, img(32'h0010002A));
    // R3 + R2 after clear: all locks open
    do_write(32'h0);
    check("R1 unlocked implemented", {16'b0, low_prot}, {16'b0, ~MASK});
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule